// File: doc/BRIEF.md
# Dual-Bus ADC Output Demultiplexer

This block sits between the digital back end of a two-channel (I and Q) converter and its output pins. Each channel delivers one 12-bit sample, with an out-of-range flag, on every sample clock. The block drives each channel's samples onto a primary bus and a delayed bus, and it forwards a data clock with them. All signals are single-ended logic. The delayed bus has an output-enable that stands in for tri-state.

In non-demuxed mode the primary bus takes a new sample on every sample clock. The delayed bus is disabled. In 1:2 demuxed mode the samples are grouped in pairs. On every second clock the primary bus shows the later sample of a pair and the delayed bus shows the earlier one.

The forwarded clock runs at half the sample rate in non-demuxed mode and at a quarter of it in demuxed mode, so data changes on both of its edges. In demuxed mode a phase select places its edges either on the data transitions (0°) or midway between them (90°). A synchronous realignment pulse restarts the clock divider and the pairing. Several devices pulsed together therefore share one phase. A per-channel power-down input quiets that channel's outputs without disturbing the other channel.

Top module: `adc_out_demux`

## Requirements
- R1: While rst_n is low, every data output, flag, output-enable and forwarded clock is 0.
- R2: With demux_mode low, the primary bus and its flag show, after each rising edge, the sample and flag presented at that edge. The delayed bus and its flag are 0 and dly_oe is 0.
- R3: With demux_mode high, index the samples from the realignment (see R4). At the rising edge that accepts an odd-index sample k, the primary bus takes sample k and the delayed bus takes sample k-1. Both buses hold between such edges, and dly_oe is 1.
- R4: A rising edge that sees dclk_sync high clears the forwarded clock to 0. The sample presented at the first following edge with dclk_sync low is index 0. The first pair therefore appears after the second such edge.
- R5: In demuxed mode with dclk_phase90 low, the forwarded clock toggles exactly on the edges that update the buses. It is 1 after the second edge following realignment, which gives a quarter-rate clock.
- R6: In demuxed mode with dclk_phase90 high, the forwarded clock toggles exactly on the edges that do not update the buses. It is 1 after the first edge following realignment.
- R7: In non-demuxed mode the forwarded clock toggles on every edge that does not see dclk_sync, whatever the value of dclk_phase90.
- R8: Each out-of-range flag leaves the block on the same edge as the sample it was presented with, and on the same bus.
- R9: While neither channel is powered down at an edge, i_dclk and q_dclk are equal after that edge.
- R10: A channel whose power-down input is high at an edge shows zero data, zero flags, dly_oe 0 and forwarded clock 0 after that edge. The other channel is unaffected. After release, its clock matches the other channel's clock from the first edge with the power-down input low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk_sync | input | 1 | Synchronous realignment pulse for the clock divider and pairing |
| demux_mode | input | 1 | 1 = 1:2 demuxed, 0 = non-demuxed |
| dclk_phase90 | input | 1 | 1 = 90° data-to-clock phase (demuxed mode only) |
| pwrdn_i | input | 1 | Power down the I channel |
| pwrdn_q | input | 1 | Power down the Q channel |
| samp_i | input | 12 | I channel sample |
| samp_i_ovr | input | 1 | I channel out-of-range flag |
| samp_q | input | 12 | Q channel sample |
| samp_q_ovr | input | 1 | Q channel out-of-range flag |
| i_pri | output | 12 | I primary bus (later sample) |
| i_pri_ovr | output | 1 | Flag for i_pri |
| i_dly | output | 12 | I delayed bus (earlier sample) |
| i_dly_ovr | output | 1 | Flag for i_dly |
| i_dly_oe | output | 1 | Drive enable for the I delayed bus |
| i_dclk | output | 1 | I forwarded data clock |
| q_pri | output | 12 | Q primary bus (later sample) |
| q_pri_ovr | output | 1 | Flag for q_pri |
| q_dly | output | 12 | Q delayed bus (earlier sample) |
| q_dly_ovr | output | 1 | Flag for q_dly |
| q_dly_oe | output | 1 | Drive enable for the Q delayed bus |
| q_dclk | output | 1 | Q forwarded data clock |

## Verification
The bench feeds ramps and checks that the delayed bus always holds the value just below the primary bus. A design that swapped the buses, or paired a sample with the wrong neighbour, breaks that order at once. It applies a realignment pulse while the divider is in mid-period and checks the clock and the first pair edge by edge. An off-by-one in the pairing phase, or a divider that is not cleared, shifts every following pair. Both phase settings are run in both modes, to catch a 90° clock that leaks into non-demuxed mode or toggles on the data edges. Power-down is released in the middle of a stream, so that a channel whose clock comes back out of step with the other channel is caught.

// File: rtl/adc_demux_pkg.sv
package adc_demux_pkg;

    // Per-cycle control shared by all lanes, produced by the timing unit.
    typedef struct packed {
        logic cap;        // accept current sample as the earlier of a pair
        logic upd;        // load the output buses this edge
        logic dclk_nxt;   // value the forwarded clock takes at this edge
        logic pair_mode;  // 1:2 demuxed operation
    } strobe_t;

endpackage

// File: rtl/adc_demux_timing.sv
module adc_demux_timing
    import adc_demux_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sync_i,
    input  logic    demux_i,
    input  logic    ph90_i,
    output strobe_t stb_o
);

    typedef struct packed {
        logic ph;    // parity of the sample index since realignment
        logic dclk;  // reference forwarded clock
    } tstate_t;

    tstate_t cur_q, nxt_d;
    logic    tgl;

    always_comb begin
        nxt_d = cur_q;
        // demuxed: 0 deg toggles with the odd sample, 90 deg with the even one
        if (demux_i) tgl = ph90_i ? ~cur_q.ph : cur_q.ph;
        else         tgl = 1'b1;
        if (sync_i) begin
            nxt_d.ph   = 1'b0;
            nxt_d.dclk = 1'b0;
        end else begin
            nxt_d.ph   = ~cur_q.ph;
            nxt_d.dclk = cur_q.dclk ^ tgl;
        end
        stb_o.cap       = ~sync_i & ~cur_q.ph;
        stb_o.upd       = demux_i ? (~sync_i & cur_q.ph) : 1'b1;
        stb_o.dclk_nxt  = nxt_d.dclk;
        stb_o.pair_mode = demux_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R4
    sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (!cur_q.ph && !cur_q.dclk));

    // R7
    fast_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!demux_i && !sync_i) |=> (cur_q.dclk != $past(cur_q.dclk)));

    // R5
    quarter_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demux_i && !ph90_i && !sync_i) |=> ((cur_q.dclk != $past(cur_q.dclk)) == $past(cur_q.ph)));

    // R6
    mid_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demux_i && ph90_i && !sync_i) |=> ((cur_q.dclk != $past(cur_q.dclk)) != $past(cur_q.ph)));

endmodule

// File: rtl/adc_demux_lane.sv
module adc_demux_lane
    import adc_demux_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       stb_i,
    input  logic          pd_i,
    input  logic [DW-1:0] din_i,
    input  logic          ovr_i,
    output logic [DW-1:0] pri_o,
    output logic          pri_ovr_o,
    output logic [DW-1:0] dly_o,
    output logic          dly_ovr_o,
    output logic          dly_oe_o,
    output logic          dclk_o
);

    typedef struct packed {
        logic [DW-1:0] hold;
        logic          hold_ovr;
        logic [DW-1:0] pri;
        logic          pri_ovr;
        logic [DW-1:0] dly;
        logic          dly_ovr;
        logic          oe;
        logic          dclk;
    } lstate_t;

    lstate_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (stb_i.cap) begin
            nxt_d.hold     = din_i;
            nxt_d.hold_ovr = ovr_i;
        end
        if (pd_i) begin
            nxt_d.pri     = '0;
            nxt_d.pri_ovr = 1'b0;
            nxt_d.dly     = '0;
            nxt_d.dly_ovr = 1'b0;
            nxt_d.oe      = 1'b0;
            nxt_d.dclk    = 1'b0;
        end else begin
            nxt_d.dclk = stb_i.dclk_nxt;
            nxt_d.oe   = stb_i.pair_mode;
            if (!stb_i.pair_mode) begin
                nxt_d.pri     = din_i;
                nxt_d.pri_ovr = ovr_i;
                nxt_d.dly     = '0;
                nxt_d.dly_ovr = 1'b0;
            end else if (stb_i.upd) begin
                nxt_d.pri     = din_i;
                nxt_d.pri_ovr = ovr_i;
                nxt_d.dly     = cur_q.hold;
                nxt_d.dly_ovr = cur_q.hold_ovr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pri_o     = cur_q.pri;
    assign pri_ovr_o = cur_q.pri_ovr;
    assign dly_o     = cur_q.dly;
    assign dly_ovr_o = cur_q.dly_ovr;
    assign dly_oe_o  = cur_q.oe;
    assign dclk_o    = cur_q.dclk;

    // R2
    dly_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i.pair_mode |=> (!dly_oe_o && dly_o == '0));

    // R3
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i.pair_mode && !stb_i.upd && !pd_i) |=> ($stable(pri_o) && $stable(dly_o)));

    // R10
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> (pri_o == '0 && dly_o == '0 && !dly_oe_o && !dclk_o));

endmodule

// File: rtl/adc_out_demux.sv
module adc_out_demux
    import adc_demux_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dclk_sync,
    input  logic          demux_mode,
    input  logic          dclk_phase90,
    input  logic          pwrdn_i,
    input  logic          pwrdn_q,
    input  logic [DW-1:0] samp_i,
    input  logic          samp_i_ovr,
    input  logic [DW-1:0] samp_q,
    input  logic          samp_q_ovr,
    output logic [DW-1:0] i_pri,
    output logic          i_pri_ovr,
    output logic [DW-1:0] i_dly,
    output logic          i_dly_ovr,
    output logic          i_dly_oe,
    output logic          i_dclk,
    output logic [DW-1:0] q_pri,
    output logic          q_pri_ovr,
    output logic [DW-1:0] q_dly,
    output logic          q_dly_ovr,
    output logic          q_dly_oe,
    output logic          q_dclk
);

    localparam int NCH = 2;

    strobe_t                  stb;
    logic [NCH-1:0]           pd_v, ovr_v, pri_ovr_v, dly_ovr_v, oe_v, dclk_v;
    logic [NCH-1:0][DW-1:0]   din_v, pri_v, dly_v;

    assign pd_v  = {pwrdn_q, pwrdn_i};
    assign ovr_v = {samp_q_ovr, samp_i_ovr};
    assign din_v = {samp_q, samp_i};

    adc_demux_timing u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (dclk_sync),
        .demux_i (demux_mode),
        .ph90_i  (dclk_phase90),
        .stb_o   (stb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        adc_demux_lane #(.DW(DW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb_i     (stb),
            .pd_i      (pd_v[c]),
            .din_i     (din_v[c]),
            .ovr_i     (ovr_v[c]),
            .pri_o     (pri_v[c]),
            .pri_ovr_o (pri_ovr_v[c]),
            .dly_o     (dly_v[c]),
            .dly_ovr_o (dly_ovr_v[c]),
            .dly_oe_o  (oe_v[c]),
            .dclk_o    (dclk_v[c])
        );
    end

    assign i_pri     = pri_v[0];
    assign i_pri_ovr = pri_ovr_v[0];
    assign i_dly     = dly_v[0];
    assign i_dly_ovr = dly_ovr_v[0];
    assign i_dly_oe  = oe_v[0];
    assign i_dclk    = dclk_v[0];
    assign q_pri     = pri_v[1];
    assign q_pri_ovr = pri_ovr_v[1];
    assign q_dly     = dly_v[1];
    assign q_dly_ovr = dly_ovr_v[1];
    assign q_dly_oe  = oe_v[1];
    assign q_dclk    = dclk_v[1];

    // R9
    dclk_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwrdn_i && !pwrdn_q) |=> (i_dclk == q_dclk));

endmodule

// File: tb/tb_adc_out_demux.sv
module tb_adc_out_demux;

    localparam int DW   = 12;
    localparam int MAXN = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dclk_sync = 1'b0, demux_mode = 1'b0, dclk_phase90 = 1'b0;
    logic pwrdn_i = 1'b0, pwrdn_q = 1'b0;
    logic [DW-1:0] samp_i = '0, samp_q = '0;
    logic samp_i_ovr = 1'b0, samp_q_ovr = 1'b0;
    logic [DW-1:0] i_pri, i_dly, q_pri, q_dly;
    logic i_pri_ovr, i_dly_ovr, i_dly_oe, i_dclk;
    logic q_pri_ovr, q_dly_ovr, q_dly_oe, q_dclk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] si [MAXN];
    logic [DW-1:0] sq [MAXN];
    logic          oi [MAXN];
    logic          oq [MAXN];

    always #2 clk = ~clk;

    adc_out_demux #(.DW(DW)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_dclk(bit dm, bit p90, int e);
        if (!dm) return e & 1;
        if (p90) return ((e + 1) >> 1) & 1;
        return (e >> 1) & 1;
    endfunction

    // Check one lane after edge e; rel = first edge with that lane powered up.
    task automatic chk_lane(bit is_q, bit dm, bit p90, bit ramp, int e, int rel);
        logic [DW-1:0] pri, dly;
        logic po, dov, oe, dc;
        int u;
        pri = is_q ? q_pri : i_pri;      dly = is_q ? q_dly : i_dly;
        po  = is_q ? q_pri_ovr : i_pri_ovr; dov = is_q ? q_dly_ovr : i_dly_ovr;
        oe  = is_q ? q_dly_oe : i_dly_oe;   dc  = is_q ? q_dclk : i_dclk;
        if (e < rel) begin
            // R10 powered-down lane is quiet
            chk(pri == 0 && dly == 0 && !po && !dov && !oe && !dc, "R10 pd quiet",
                {pri, dly, 1'(oe), 1'(dc)}, 0);
            return;
        end
        chk(dc == 1'(exp_dclk(dm, p90, e)), dm ? (p90 ? "R6 dclk 90" : "R5 dclk 0") : "R7 dclk half",
            dc, exp_dclk(dm, p90, e));
        if (!dm) begin
            chk(pri == (is_q ? sq[e-1] : si[e-1]), "R2 pri", pri, is_q ? sq[e-1] : si[e-1]);
            chk(!oe && dly == 0, "R2 dly off", {oe, dly}, 0);
            chk(po == (is_q ? oq[e-1] : oi[e-1]), "R8 pri ovr", po, is_q ? oq[e-1] : oi[e-1]);
        end else begin
            chk(oe, "R3 dly oe", oe, 1);
            u = (e % 2 == 0) ? e : e - 1;
            if (u >= 2 && u >= rel) begin
                chk(pri == (is_q ? sq[u-1] : si[u-1]), "R3 pri later", pri, is_q ? sq[u-1] : si[u-1]);
                chk(dly == (is_q ? sq[u-2] : si[u-2]), "R3 dly earlier", dly, is_q ? sq[u-2] : si[u-2]);
                chk(po == (is_q ? oq[u-1] : oi[u-1]) && dov == (is_q ? oq[u-2] : oi[u-2]),
                    "R8 pair ovr", {po, dov}, {is_q ? oq[u-1] : oi[u-1], is_q ? oq[u-2] : oi[u-2]});
                if (ramp) chk(DW'(dly + 1) == pri, "R3 ramp order", dly, pri - 1);
            end
        end
    endtask

    task automatic drive(int k);
        samp_i = si[k]; samp_q = sq[k]; samp_i_ovr = oi[k]; samp_q_ovr = oq[k];
    endtask

    // One realignment pulse followed by n samples; Q lane powered down for edges < rel.
    task automatic run_seg(bit dm, bit p90, int n, int rel, bit ramp);
        int bi, bq;
        bi = int'($urandom) & 12'hFFF; bq = int'($urandom) & 12'hFFF;
        for (int k = 0; k < n; k++) begin
            si[k] = ramp ? DW'(bi + k) : DW'($urandom);
            sq[k] = ramp ? DW'(bq + k) : DW'($urandom);
            oi[k] = 1'($urandom); oq[k] = 1'($urandom);
        end
        @(negedge clk);
        dclk_sync = 1'b1; demux_mode = dm; dclk_phase90 = p90; pwrdn_q = (rel > 0);
        @(negedge clk);
        // R4 clock cleared by the realignment edge
        chk(i_dclk == 1'b0, "R4 dclk cleared", i_dclk, 0);
        dclk_sync = 1'b0; pwrdn_q = (rel > 1); drive(0);
        for (int e = 1; e <= n; e++) begin
            @(negedge clk);
            if (dm && e == 2) chk(i_pri == si[1] && i_dly == si[0], "R4 first pair", {i_pri, i_dly}, {si[1], si[0]});
            chk_lane(1'b0, dm, p90, ramp, e, 0);
            chk_lane(1'b1, dm, p90, ramp, e, rel);
            if (e >= rel) chk(i_dclk == q_dclk, "R9 dclk in phase", q_dclk, i_dclk);
            pwrdn_q = (rel > e + 1);
            if (e < n) drive(e);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1 reset state
        chk({i_pri, i_dly, q_pri, q_dly} == 0 && !i_dly_oe && !q_dly_oe && !i_dclk && !q_dclk
            && !i_pri_ovr && !q_dly_ovr, "R1 reset", {i_dly_oe, i_dclk, q_dclk}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // directed corners
        run_seg(1'b0, 1'b0, 12, 0, 1'b1);
        run_seg(1'b0, 1'b1, 12, 0, 1'b1);
        run_seg(1'b1, 1'b0, 16, 0, 1'b1);
        run_seg(1'b1, 1'b1, 16, 0, 1'b1);
        run_seg(1'b1, 1'b0, 3,  0, 1'b1);   // realign mid-period
        run_seg(1'b1, 1'b1, 5,  0, 1'b1);
        run_seg(1'b1, 1'b0, 14, 15, 1'b1);  // Q down for the whole segment
        run_seg(1'b1, 1'b1, 20, 7, 1'b1);   // Q released mid-stream
        run_seg(1'b0, 1'b0, 12, 4, 1'b0);
        // random segments
        for (int s = 0; s < 30; s++) begin
            int n, rel;
            n   = 4 + int'($urandom % 40);
            rel = ($urandom % 3 == 0) ? int'($urandom % (n + 2)) : 0;
            run_seg(1'($urandom), 1'($urandom), n, rel, 1'($urandom));
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

endmodule